// File: doc/BRIEF.md
# Trap Privilege Delegation Unit

This block decides which privilege level takes a synchronous exception. Each request carries a cause code and the privilege level that was running when the exception was raised. Two per-cause delegation masks are held inside the block. The machine-level mask can hand a cause down to supervisor mode. The supervisor-level mask can hand it further down to user mode. Each hand-off also needs the matching extension-enable input to be set.

The answer is registered. It appears one cycle after the request, together with a valid flag. The result is never lower than the privilege the exception came from. A simple write port loads either mask. A request made in the same cycle as a write sees the mask contents from before the write. The trap sequencer issues a request whenever an exception is raised, and uses the answer to choose which handler state to enter.

Top module: `trap_deleg_unit`

## Requirements
- R1: After reset both delegation masks are zero and `tgt_valid_o` is low, so any request resolves to Machine (2'b11).
- R2: `tgt_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high, and low in every other cycle. Back-to-back requests each get their own result.
- R3: When `n_ext_en_i` is 1 and bit `cause_i` of the supervisor-level mask is 1, the selected level is User (2'b00).
- R4: When User is not selected, `s_ext_en_i` is 1 and bit `cause_i` of the machine-level mask is 1, the selected level is Supervisor (2'b01).
- R5: When neither User nor Supervisor is selected, the selected level is Machine (2'b11).
- R6: A supervisor-level mask bit has no effect while `n_ext_en_i` is 0. A machine-level mask bit has no effect while `s_ext_en_i` is 0.
- R7: When the selected level's 2-bit encoding is unsigned-less-than `cur_priv_i`, `tgt_priv_o` carries `cur_priv_i` instead (U=00, S=01, M=11).
- R8: A cause code of NUM_CAUSES (16) or above is not delegable. It selects Machine before the clamp.
- R9: With `csr_we_i` high, `csr_sel_i`=0 loads the machine-level mask and `csr_sel_i`=1 loads the supervisor-level mask from `csr_wdata_i`. With `csr_we_i` low, neither mask changes. A request in the same cycle as a write uses the contents from before the write.
- R10: User delegation is checked before Supervisor delegation. When both bits are set and both enables are high, the selected level is User, and the clamp is then applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Exception request present |
| cause_i | input | CAUSE_W (5) | Exception cause code |
| cur_priv_i | input | 2 | Privilege level at which the exception occurred |
| s_ext_en_i | input | 1 | Supervisor mode extension enabled |
| n_ext_en_i | input | 1 | User-level interrupt extension enabled |
| csr_we_i | input | 1 | Mask write enable |
| csr_sel_i | input | 1 | Mask select: 0 machine-level, 1 supervisor-level |
| csr_wdata_i | input | NUM_CAUSES (16) | Mask write data, one bit per cause |
| tgt_valid_o | output | 1 | Result valid, one cycle after the request |
| tgt_priv_o | output | 2 | Privilege level that handles the exception |

## Verification
The bench uses the default parameters: NUM_CAUSES=16 and a 5-bit cause input. With these values, every bit position of both 16-bit masks can be reached, and so can the non-delegable codes 16 to 31. Codes 16 to 31 include values whose low four bits match a set mask bit, so the bench can confirm that such a code still resolves to Machine. The three legal privilege encodings are combined with every pairing of the two enables, so the chain order and the clamp are each reached from every starting level.

// File: rtl/trap_deleg_pkg.sv
package trap_deleg_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned NUM_MASKS = 2;
  localparam int unsigned MASK_MACH = 0;
  localparam int unsigned MASK_SUP  = 1;
endpackage

// File: rtl/deleg_mask_bank.sv
module deleg_mask_bank #(
  parameter int unsigned NUM_CAUSES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  sel_i,
  input  logic [NUM_CAUSES-1:0] wdata_i,
  output logic [NUM_CAUSES-1:0] mach_mask_o,
  output logic [NUM_CAUSES-1:0] sup_mask_o
);
  import trap_deleg_pkg::*;

  logic [NUM_CAUSES-1:0] mask_q [NUM_MASKS];

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
    logic hit;
    assign hit = we_i && (sel_i == 1'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mask_q[g] <= '0;
      else if (hit) mask_q[g] <= wdata_i;
    end
  end

  assign mach_mask_o = mask_q[MASK_MACH];
  assign sup_mask_o  = mask_q[MASK_SUP];
endmodule

// File: rtl/deleg_resolve.sv
module deleg_resolve #(
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned CAUSE_W    = 5
) (
  input  logic [CAUSE_W-1:0]    cause_i,
  input  logic [1:0]            cur_priv_i,
  input  logic                  s_ext_en_i,
  input  logic                  n_ext_en_i,
  input  logic [NUM_CAUSES-1:0] mach_mask_i,
  input  logic [NUM_CAUSES-1:0] sup_mask_i,
  output logic [1:0]            tgt_priv_o
);
  import trap_deleg_pkg::*;

  localparam int unsigned IDX_W = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1;

  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              mach_bit, sup_bit;
  priv_e             sel_priv;

  assign in_range = 32'(cause_i) < NUM_CAUSES;
  assign idx      = IDX_W'(cause_i);
  assign mach_bit = in_range && mach_mask_i[idx];
  assign sup_bit  = in_range && sup_mask_i[idx];

  // User checked first, then Supervisor, then Machine
  always_comb begin
    if (n_ext_en_i && sup_bit)       sel_priv = PRIV_U;
    else if (s_ext_en_i && mach_bit) sel_priv = PRIV_S;
    else                             sel_priv = PRIV_M;
  end

  // never hand a trap to a lower level than its origin
  assign tgt_priv_o = (sel_priv < cur_priv_i) ? cur_priv_i : sel_priv;
endmodule

// File: rtl/trap_deleg_unit.sv
module trap_deleg_unit #(
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned CAUSE_W    = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [CAUSE_W-1:0]    cause_i,
  input  logic [1:0]            cur_priv_i,
  input  logic                  s_ext_en_i,
  input  logic                  n_ext_en_i,
  input  logic                  csr_we_i,
  input  logic                  csr_sel_i,
  input  logic [NUM_CAUSES-1:0] csr_wdata_i,
  output logic                  tgt_valid_o,
  output logic [1:0]            tgt_priv_o
);
  import trap_deleg_pkg::*;

  logic [NUM_CAUSES-1:0] mach_mask, sup_mask;
  logic [1:0]            res_priv;
  logic                  valid_q;
  logic [1:0]            priv_q;

  deleg_mask_bank #(.NUM_CAUSES(NUM_CAUSES)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (csr_we_i),
    .sel_i       (csr_sel_i),
    .wdata_i     (csr_wdata_i),
    .mach_mask_o (mach_mask),
    .sup_mask_o  (sup_mask)
  );

  deleg_resolve #(.NUM_CAUSES(NUM_CAUSES), .CAUSE_W(CAUSE_W)) u_resolve (
    .cause_i     (cause_i),
    .cur_priv_i  (cur_priv_i),
    .s_ext_en_i  (s_ext_en_i),
    .n_ext_en_i  (n_ext_en_i),
    .mach_mask_i (mach_mask),
    .sup_mask_i  (sup_mask),
    .tgt_priv_o  (res_priv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      priv_q  <= PRIV_M;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) priv_q <= res_priv;
    end
  end

  assign tgt_valid_o = valid_q;
  assign tgt_priv_o  = priv_q;
endmodule

// File: rtl/trap_deleg_unit_chk.sv
module trap_deleg_unit_chk #(
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned CAUSE_W    = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [1:0]         cur_priv_i,
  input logic               s_ext_en_i,
  input logic               n_ext_en_i,
  input logic               tgt_valid_o,
  input logic [1:0]         tgt_priv_o
);
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> tgt_valid_o);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !tgt_valid_o);  // R2
  AST_NO_DOWNGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (tgt_priv_o >= $past(cur_priv_i)));  // R7
  AST_NONDELEG_MACHINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (32'(cause_i) >= NUM_CAUSES)) |=> (tgt_priv_o == 2'b11));  // R8
  AST_NO_USER_WITHOUT_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !n_ext_en_i) |=> (tgt_priv_o != 2'b00));  // R6
  AST_NO_SUP_WITHOUT_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !s_ext_en_i && !n_ext_en_i && cur_priv_i != 2'b01)
      |=> (tgt_priv_o != 2'b01));  // R6
endmodule

bind trap_deleg_unit trap_deleg_unit_chk #(.NUM_CAUSES(NUM_CAUSES), .CAUSE_W(CAUSE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .cause_i     (cause_i),
  .cur_priv_i  (cur_priv_i),
  .s_ext_en_i  (s_ext_en_i),
  .n_ext_en_i  (n_ext_en_i),
  .tgt_valid_o (tgt_valid_o),
  .tgt_priv_o  (tgt_priv_o)
);

// File: tb/trap_deleg_unit_bench.sv
`timescale 1ns/1ps
module trap_deleg_unit_bench;
  localparam int unsigned NC = 16;
  localparam int unsigned CW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [CW-1:0] cause_i = '0;
  logic [1:0]    cur_priv_i = 2'b00;
  logic          s_ext_en_i = 1'b0;
  logic          n_ext_en_i = 1'b0;
  logic          csr_we_i = 1'b0;
  logic          csr_sel_i = 1'b0;
  logic [NC-1:0] csr_wdata_i = '0;
  logic          tgt_valid_o;
  logic [1:0]    tgt_priv_o;

  int errors = 0;
  int checks = 0;
  logic [NC-1:0] m_mask = '0;
  logic [NC-1:0] s_mask = '0;

  always #5 clk_i = ~clk_i;

  trap_deleg_unit #(.NUM_CAUSES(NC), .CAUSE_W(CW)) u_trap_deleg_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .cause_i(cause_i),
    .cur_priv_i(cur_priv_i), .s_ext_en_i(s_ext_en_i), .n_ext_en_i(n_ext_en_i),
    .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
    .tgt_valid_o(tgt_valid_o), .tgt_priv_o(tgt_priv_o)
  );

  function automatic logic [1:0] exp_priv(input logic [CW-1:0] c, input logic [1:0] cur,
                                          input logic s_en, input logic n_en);
    logic [1:0] d;
    d = 2'b11;
    if (32'(c) < NC) begin
      if (n_en && s_mask[c[3:0]])      d = 2'b00;
      else if (s_en && m_mask[c[3:0]]) d = 2'b01;
    end
    if (d < cur) d = cur;
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check after the following posedge
  task automatic step(input bit req, input logic [CW-1:0] c, input logic [1:0] cur,
                      input bit s_en, input bit n_en, input bit we, input bit sel,
                      input logic [NC-1:0] wd, input string tag);
    logic [1:0] e;
    req_valid_i = req; cause_i = c; cur_priv_i = cur;
    s_ext_en_i = s_en; n_ext_en_i = n_en;
    csr_we_i = we; csr_sel_i = sel; csr_wdata_i = wd;
    e = exp_priv(c, cur, s_en, n_en);  // pre-write contents (R9)
    if (we) begin
      if (sel) s_mask = wd;
      else     m_mask = wd;
    end
    @(posedge clk_i); #1;
    chk(tgt_valid_o == req, {tag, " R2 valid"}, int'(tgt_valid_o), int'(req));
    if (req) chk(tgt_priv_o == e, tag, int'(tgt_priv_o), int'(e));
    @(negedge clk_i);
  endtask

  task automatic wr(input bit sel, input logic [NC-1:0] wd);
    step(1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b1, sel, wd, "R9 write");
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] legal [3];
    legal[0] = 2'b00; legal[1] = 2'b01; legal[2] = 2'b11;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    chk(tgt_valid_o == 1'b0, "R1 reset valid", int'(tgt_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tgt_valid_o == 1'b0, "R1 idle after reset", int'(tgt_valid_o), 0);
    step(1, 5'd3, 2'b00, 1, 1, 0, 0, '0, "R1 zero masks -> M");
    step(1, 5'd0, 2'b00, 1, 1, 0, 0, '0, "R1 zero masks cause0");

    wr(1'b0, 16'h0008);
    step(1, 5'd3, 2'b00, 1, 0, 0, 0, '0, "R4 supervisor delegation");
    step(1, 5'd3, 2'b00, 0, 0, 0, 0, '0, "R6 s_ext disabled");
    step(1, 5'd4, 2'b00, 1, 1, 0, 0, '0, "R5 other cause machine");
    wr(1'b1, 16'h0008);
    step(1, 5'd3, 2'b00, 1, 1, 0, 0, '0, "R10 user before supervisor");
    step(1, 5'd3, 2'b00, 0, 1, 0, 0, '0, "R3 user delegation");
    step(1, 5'd3, 2'b00, 1, 0, 0, 0, '0, "R6 n_ext disabled");
    step(1, 5'd3, 2'b01, 1, 1, 0, 0, '0, "R7 clamp to S");
    step(1, 5'd3, 2'b11, 1, 1, 0, 0, '0, "R7 clamp to M");
    step(1, 5'd19, 2'b00, 1, 1, 0, 0, '0, "R8 alias code 19");
    step(1, 5'd16, 2'b00, 1, 1, 0, 0, '0, "R8 code 16");
    step(1, 5'd31, 2'b00, 1, 1, 0, 0, '0, "R8 code 31");
    step(0, 5'd3, 2'b00, 1, 1, 0, 0, '0, "R2 idle");
    // same-cycle write and request sees old mask
    step(1, 5'd3, 2'b00, 1, 0, 1, 0, 16'h0000, "R9 same-cycle old value");
    step(1, 5'd3, 2'b00, 1, 0, 0, 0, '0, "R9 new value");
    // we low: data ignored
    step(1, 5'd3, 2'b00, 1, 0, 0, 0, 16'hFFFF, "R9 we low ignored");
    step(1, 5'd3, 2'b00, 1, 1, 0, 1, 16'h0000, "R9 we low sup mask kept");
    wr(1'b0, 16'h8000);
    wr(1'b1, 16'h0001);
    step(1, 5'd15, 2'b00, 1, 1, 0, 0, '0, "R4 top bit");
    step(1, 5'd0, 2'b00, 1, 1, 0, 0, '0, "R3 bottom bit");

    for (int i = 0; i < 600; i++) begin
      logic [NC-1:0] wd;
      bit we;
      wd = NC'($urandom);
      we = ($urandom % 4) == 0;
      step(($urandom % 4) != 0, CW'($urandom), legal[$urandom % 3],
           1'($urandom), 1'($urandom), we, 1'($urandom), wd, "R3/R4/R5/R7 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule